// File: doc/BRIEF.md
# Sensor Row Overhead Timing Sequencer

This block produces the burst of control pulses an image sensor needs each time a new set of rows is selected, covering the interval between that selection and the moment the first pixel of the line may be sampled. A single line-start strobe launches a sequence. Every duration in the sequence is a cycle count held in a register. At the intended 200 MHz clock, one cycle is 5 ns.

In standard mode, the row-select and column-precharge pulses are followed by a settle window. The active-low column sample-and-hold output is held low the whole time. In sample-and-hold mode, that output instead goes low for a programmable track window that starts with the row pulses. Readout may begin once it returns high. If averaging is enabled, a short averaging pulse is first inserted after the track window. Either mode may add a narrow pulse on both bus-precharge outputs right after the row pulses end.

A one-cycle ready flag marks the end of each sequence. A strobe that arrives while a sequence is running is discarded and sets a sticky error flag. All configuration inputs are captured when a strobe is accepted.

Top module: `rowovh_seq`

## Requirements
In these requirements, t is the number of clock edges after the edge that accepts a line start. The outputs seen right after that accepting edge are t=0. `mode_sh`=0 selects standard mode and `mode_sh`=1 selects sample-and-hold mode. P, S, H, C and A are the values of `pulse_len`, `settle_len`, `hold_len`, `pchg_len` and `avg_len`.
- R1: `row_sel` and `col_pre` are both high for exactly t = 0 .. P-1 of every sequence, and low otherwise.
- R2: In standard mode, `ready` is high only at t = P+S, which ends the sequence.
- R3: In standard mode, `sh_n` is 0 throughout the sequence and stays 0 while idle afterwards.
- R4: In sample-and-hold mode, `sh_n` is 0 for t = 0 .. H-1 and 1 from t = H onward, including while idle afterwards. With averaging off, `ready` is high only at t = H.
- R5: In sample-and-hold mode with `avg_en`=1, `avg_pulse` is high for t = H .. H+A-1 and `ready` moves to t = H+A. In standard mode, `avg_en` has no effect and `avg_pulse` stays 0.
- R6: With `pchg_en`=1, every bit of `bus_pre` is high for t = P .. P+C-1, and all other outputs are unchanged. The configuration must satisfy P+C no greater than the sequence end.
- R7: `ready` lasts exactly one cycle. A strobe present during the ready cycle is accepted at the next edge, so lines can run back to back.
- R8: A strobe that arrives while a sequence is running changes no output of that sequence. It sets `seq_err`, which stays 1 until reset.
- R9: Changes on the mode, enable and length inputs after a strobe has been accepted have no effect on that sequence.
- R10: After reset, `row_sel`, `col_pre`, `bus_pre`, `avg_pulse`, `ready` and `seq_err` are 0, and `sh_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per time unit of all lengths |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | New row set selected; starts a sequence when idle |
| mode_sh | input | 1 | 0 standard, 1 sample-and-hold |
| pchg_en | input | 1 | Adds the bus-precharge pulse |
| avg_en | input | 1 | Adds the averaging pulse in sample-and-hold mode |
| pulse_len | input | CW | Row/column pulse length P (default use 4) |
| settle_len | input | CW | Standard-mode settle length S (default use 36) |
| hold_len | input | CW | Track window length H (20 to 40) |
| pchg_len | input | CW | Bus-precharge length C (default use 1) |
| avg_len | input | CW | Averaging pulse length A |
| row_sel | output | 1 | Row-select pulse |
| col_pre | output | 1 | Column-precharge pulse |
| sh_n | output | 1 | Column sample-and-hold, active low |
| bus_pre | output | NBUS | Bus-precharge pulses, all bits identical |
| avg_pulse | output | 1 | Averaging pulse |
| ready | output | 1 | One-cycle readout-ready flag |
| seq_err | output | 1 | Sticky flag for a strobe seen while busy |

## Verification
A wrong count or a mode bit corrupted inside a sequence shows at the ports in the same cycle. One pulse edge, the `sh_n` level, or the `ready` position moves by at least one cycle, so a cycle-exact comparison of every output on every cycle of the line catches it within that line. Configuration that leaks through the capture stage only appears when the inputs change during a sequence, so a strobe and new settings are applied mid-line to expose it. A busy flag that clears too early shows as a restarted row pulse and a missing error flag within a few cycles of the stray strobe.

// File: rtl/rowovh_pkg.sv
package rowovh_pkg;

    typedef enum logic [1:0] {
        MD_NONE = 2'd0,
        MD_STD  = 2'd1,
        MD_SH   = 2'd2
    } mode_e;

endpackage

// File: rtl/rowovh_cfg_latch.sv
module rowovh_cfg_latch #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          mode_sh,
    input  logic          pchg_en,
    input  logic          avg_en,
    input  logic [CW-1:0] pulse_len,
    input  logic [CW-1:0] settle_len,
    input  logic [CW-1:0] hold_len,
    input  logic [CW-1:0] pchg_len,
    input  logic [CW-1:0] avg_len,
    output logic          eff_sh,
    output logic          eff_pchg,
    output logic          eff_avg,
    output logic [CW-1:0] eff_p,
    output logic [CW-1:0] eff_s,
    output logic [CW-1:0] eff_h,
    output logic [CW-1:0] eff_c,
    output logic [CW-1:0] eff_a
);

    typedef struct packed {
        logic          sh;
        logic          pchg;
        logic          avg;
        logic [CW-1:0] p;
        logic [CW-1:0] s;
        logic [CW-1:0] h;
        logic [CW-1:0] c;
        logic [CW-1:0] a;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    // Capture on an accepted strobe, otherwise keep the held copy.
    always_comb begin
        cfg_d = cfg_q;
        if (accept) begin
            cfg_d.sh   = mode_sh;
            cfg_d.pchg = pchg_en;
            cfg_d.avg  = avg_en;
            cfg_d.p    = pulse_len;
            cfg_d.s    = settle_len;
            cfg_d.h    = hold_len;
            cfg_d.c    = pchg_len;
            cfg_d.a    = avg_len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign eff_sh   = cfg_d.sh;
    assign eff_pchg = cfg_d.pchg;
    assign eff_avg  = cfg_d.avg;
    assign eff_p    = cfg_d.p;
    assign eff_s    = cfg_d.s;
    assign eff_h    = cfg_d.h;
    assign eff_c    = cfg_d.c;
    assign eff_a    = cfg_d.a;

endmodule

// File: rtl/rowovh_core.sv
module rowovh_core
    import rowovh_pkg::*;
#(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_start,
    input  logic          eff_sh,
    input  logic          eff_pchg,
    input  logic          eff_avg,
    input  logic [CW-1:0] eff_p,
    input  logic [CW-1:0] eff_s,
    input  logic [CW-1:0] eff_h,
    input  logic [CW-1:0] eff_c,
    input  logic [CW-1:0] eff_a,
    output logic          accept,
    output logic          row_o,
    output logic          col_o,
    output logic          shn_o,
    output logic          bus_o,
    output logic          avg_o,
    output logic          rdy_o,
    output logic          err_o
);

    localparam int unsigned TW = CW + 2;

    typedef struct packed {
        logic          busy;
        logic [TW-1:0] t;
        mode_e         mode;
        logic          row;
        logic          col;
        logic          shn;
        logic          bus;
        logic          avg;
        logic          rdy;
        logic          err;
    } st_t;

    st_t st_d, st_q;

    logic          run;
    logic          hit;
    logic [TW-1:0] t_nx;
    logic [TW-1:0] p_w, s_w, h_w, c_w, a_w;
    logic [TW-1:0] end_t;

    assign accept = line_start && !st_q.busy;

    assign p_w = TW'(eff_p);
    assign s_w = TW'(eff_s);
    assign h_w = TW'(eff_h);
    assign c_w = TW'(eff_c);
    assign a_w = TW'(eff_a);

    always_comb begin
        st_d  = st_q;
        run   = accept || st_q.busy;
        t_nx  = accept ? '0 : (st_q.t + TW'(1));
        if (eff_sh) begin
            end_t = h_w + (eff_avg ? a_w : '0);
        end else begin
            end_t = p_w + s_w;
        end
        hit = run && (t_nx == end_t);

        if (accept) begin
            st_d.mode = eff_sh ? MD_SH : MD_STD;
        end
        st_d.busy = run && !hit;
        st_d.t    = run ? t_nx : st_q.t;
        st_d.row  = run && (t_nx < p_w);
        st_d.col  = run && (t_nx < p_w);
        st_d.bus  = run && eff_pchg && (t_nx >= p_w) && (t_nx < p_w + c_w);
        st_d.avg  = run && eff_sh && eff_avg && (t_nx >= h_w) && (t_nx < h_w + a_w);
        st_d.rdy  = hit;
        st_d.err  = st_q.err || (line_start && st_q.busy);

        unique case (st_d.mode)
            MD_STD:  st_d.shn = 1'b0;
            MD_SH:   st_d.shn = !(run && (t_nx < h_w));
            default: st_d.shn = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= MD_NONE;
            st_q.shn  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign row_o = st_q.row;
    assign col_o = st_q.col;
    assign shn_o = st_q.shn;
    assign bus_o = st_q.bus;
    assign avg_o = st_q.avg;
    assign rdy_o = st_q.rdy;
    assign err_o = st_q.err;

    // R1: a rising row pulse is always caused by an accepted strobe
    assert_row_on_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.row) |-> $past(accept));

    // R3: standard mode keeps the hold output low while busy
    assert_shn_std_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.mode == MD_STD) |-> !st_q.shn);

    // R5: averaging only after the track window has closed
    assert_avg_after_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.avg |-> (st_q.shn && st_q.mode == MD_SH));

    // R6: bus precharge never overlaps the row pulse
    assert_bus_after_row_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.bus |-> !st_q.row);

    // R7: ready is a single-cycle flag
    assert_rdy_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rdy |=> !st_q.rdy);

    // R8: error flag is sticky
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |=> st_q.err);

    // R8: strobe while busy raises the error flag
    assert_busy_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && st_q.busy) |=> st_q.err);

endmodule

// File: rtl/rowovh_seq.sv
module rowovh_seq #(
    parameter int unsigned CW   = 8,
    parameter int unsigned NBUS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_start,
    input  logic            mode_sh,
    input  logic            pchg_en,
    input  logic            avg_en,
    input  logic [CW-1:0]   pulse_len,
    input  logic [CW-1:0]   settle_len,
    input  logic [CW-1:0]   hold_len,
    input  logic [CW-1:0]   pchg_len,
    input  logic [CW-1:0]   avg_len,
    output logic            row_sel,
    output logic            col_pre,
    output logic            sh_n,
    output logic [NBUS-1:0] bus_pre,
    output logic            avg_pulse,
    output logic            ready,
    output logic            seq_err
);

    logic          accept;
    logic          eff_sh, eff_pchg, eff_avg;
    logic [CW-1:0] eff_p, eff_s, eff_h, eff_c, eff_a;
    logic          bus_one;

    rowovh_cfg_latch #(.CW(CW)) cfg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .mode_sh    (mode_sh),
        .pchg_en    (pchg_en),
        .avg_en     (avg_en),
        .pulse_len  (pulse_len),
        .settle_len (settle_len),
        .hold_len   (hold_len),
        .pchg_len   (pchg_len),
        .avg_len    (avg_len),
        .eff_sh     (eff_sh),
        .eff_pchg   (eff_pchg),
        .eff_avg    (eff_avg),
        .eff_p      (eff_p),
        .eff_s      (eff_s),
        .eff_h      (eff_h),
        .eff_c      (eff_c),
        .eff_a      (eff_a)
    );

    rowovh_core #(.CW(CW)) core_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .eff_sh     (eff_sh),
        .eff_pchg   (eff_pchg),
        .eff_avg    (eff_avg),
        .eff_p      (eff_p),
        .eff_s      (eff_s),
        .eff_h      (eff_h),
        .eff_c      (eff_c),
        .eff_a      (eff_a),
        .accept     (accept),
        .row_o      (row_sel),
        .col_o      (col_pre),
        .shn_o      (sh_n),
        .bus_o      (bus_one),
        .avg_o      (avg_pulse),
        .rdy_o      (ready),
        .err_o      (seq_err)
    );

    // One registered precharge pulse fans out to every bus line.
    for (genvar gi = 0; gi < NBUS; gi++) begin : g_bus
        assign bus_pre[gi] = bus_one;
    end

endmodule

// File: tb/rowovh_seq_tb_top.sv
module rowovh_seq_tb_top;

    localparam int CW   = 8;
    localparam int NBUS = 2;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            line_start;
    logic            mode_sh, pchg_en, avg_en;
    logic [CW-1:0]   pulse_len, settle_len, hold_len, pchg_len, avg_len;
    logic            row_sel, col_pre, sh_n, avg_pulse, ready, seq_err;
    logic [NBUS-1:0] bus_pre;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    bit mon_en = 1'b0;
    bit idle_shn = 1'b1;

    typedef struct {
        bit    row, col, shn, bus, avg, rdy;
        string tag_sh;
        string tag_rdy;
    } item_t;

    item_t exp_q[$];

    always #4 clk = ~clk;

    rowovh_seq #(.CW(CW), .NBUS(NBUS)) dut_i (
        .clk(clk), .rst_n(rst_n), .line_start(line_start),
        .mode_sh(mode_sh), .pchg_en(pchg_en), .avg_en(avg_en),
        .pulse_len(pulse_len), .settle_len(settle_len), .hold_len(hold_len),
        .pchg_len(pchg_len), .avg_len(avg_len),
        .row_sel(row_sel), .col_pre(col_pre), .sh_n(sh_n), .bus_pre(bus_pre),
        .avg_pulse(avg_pulse), .ready(ready), .seq_err(seq_err)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int seq_end(input bit sh, input bit av, input int p, input int s,
                                   input int h, input int a);
        return sh ? (h + (av ? a : 0)) : (p + s);
    endfunction

    // Expected outputs at step t, straight from the requirement text.
    function automatic item_t expect_at(input int t, input bit sh, input bit pc, input bit av,
                                        input int p, input int s, input int h,
                                        input int c, input int a);
        item_t it;
        int e;
        e = seq_end(sh, av, p, s, h, a);
        it.row = (t < p);
        it.col = (t < p);
        it.bus = pc && (t >= p) && (t < p + c);
        it.avg = sh && av && (t >= h) && (t < h + a);
        it.shn = sh ? (t >= h) : 1'b0;
        it.rdy = (t == e);
        it.tag_sh  = sh ? "R4" : "R3";
        it.tag_rdy = sh ? (av ? "R5" : "R4") : "R2";
        return it;
    endfunction

    // Monitor: pops one expected item per cycle, checks idle levels otherwise.
    always @(negedge clk) begin
        if (mon_en) begin
            if (exp_q.size() != 0) begin
                item_t it;
                it = exp_q.pop_front();
                chk("R1", "row_sel", int'(row_sel), int'(it.row));
                chk("R1", "col_pre", int'(col_pre), int'(it.col));
                chk(it.tag_sh, "sh_n", int'(sh_n), int'(it.shn));
                chk("R6", "bus_pre", int'(bus_pre), it.bus ? 3 : 0);
                chk("R5", "avg_pulse", int'(avg_pulse), int'(it.avg));
                chk(it.tag_rdy, "ready", int'(ready), int'(it.rdy));
            end else begin
                chk("R1", "idle row_sel", int'(row_sel), 0);
                chk("R6", "idle bus_pre", int'(bus_pre), 0);
                chk("R5", "idle avg_pulse", int'(avg_pulse), 0);
                chk("R7", "idle ready", int'(ready), 0);
                chk("R3/R4", "idle sh_n", int'(sh_n), int'(idle_shn));
            end
        end
    end

    // Driver: called at a negedge, returns at the negedge inside the ready cycle.
    task automatic run_line(input bit sh, input bit pc, input bit av,
                            input int p, input int s, input int h,
                            input int c, input int a, input bit disturb);
        int e;
        int n;
        mode_sh    = sh;
        pchg_en    = pc;
        avg_en     = av;
        pulse_len  = CW'(p);
        settle_len = CW'(s);
        hold_len   = CW'(h);
        pchg_len   = CW'(c);
        avg_len    = CW'(a);
        line_start = 1'b1;
        e = seq_end(sh, av, p, s, h, a);
        @(posedge clk);
        for (int t = 0; t <= e; t++) begin
            exp_q.push_back(expect_at(t, sh, pc, av, p, s, h, c, a));
        end
        idle_shn = sh;
        @(negedge clk);
        line_start = 1'b0;
        n = 1;
        if (disturb) begin
            // R8 / R9: stray strobe plus new settings in mid-line
            @(negedge clk);
            line_start = 1'b1;
            mode_sh    = ~sh;
            pchg_en    = ~pc;
            avg_en     = ~av;
            pulse_len  = CW'(9);
            settle_len = CW'(2);
            hold_len   = CW'(3);
            @(negedge clk);
            line_start = 1'b0;
            n = 3;
        end
        repeat (e + 1 - n) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        line_start = 1'b0;
        mode_sh = 1'b0; pchg_en = 1'b0; avg_en = 1'b0;
        pulse_len = CW'(4); settle_len = CW'(36); hold_len = CW'(20);
        pchg_len = CW'(1); avg_len = CW'(2);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10", "reset row_sel", int'(row_sel), 0);
        chk("R10", "reset col_pre", int'(col_pre), 0);
        chk("R10", "reset sh_n", int'(sh_n), 1);
        chk("R10", "reset bus_pre", int'(bus_pre), 0);
        chk("R10", "reset avg_pulse", int'(avg_pulse), 0);
        chk("R10", "reset ready", int'(ready), 0);
        chk("R10", "reset seq_err", int'(seq_err), 0);
        mon_en = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R2 R3: standard mode with default lengths
        run_line(1'b0, 1'b0, 1'b0, 4, 36, 20, 1, 2, 1'b0);
        repeat (3) @(negedge clk);
        // R6: standard mode with bus precharge
        run_line(1'b0, 1'b1, 1'b0, 4, 36, 20, 1, 2, 1'b0);
        repeat (3) @(negedge clk);
        // R4: sample-and-hold, shortest window
        run_line(1'b1, 1'b0, 1'b0, 4, 36, 20, 1, 2, 1'b0);
        repeat (3) @(negedge clk);
        // R5 R6: longest window, averaging and a two-cycle precharge
        run_line(1'b1, 1'b1, 1'b1, 4, 36, 40, 2, 3, 1'b0);
        repeat (3) @(negedge clk);
        // R5: averaging enable ignored in standard mode
        run_line(1'b0, 1'b0, 1'b1, 2, 5, 20, 1, 3, 1'b0);
        repeat (3) @(negedge clk);
        chk("R8", "seq_err before stray strobe", int'(seq_err), 0);
        // R8 R9: stray strobe and config change during a sample-and-hold line
        run_line(1'b1, 1'b0, 1'b0, 4, 36, 30, 1, 2, 1'b1);
        @(negedge clk);
        chk("R8", "seq_err after stray strobe", int'(seq_err), 1);
        repeat (2) @(negedge clk);
        // R7: back-to-back lines, strobe during the ready cycle
        run_line(1'b0, 1'b1, 1'b0, 3, 6, 20, 2, 2, 1'b0);
        run_line(1'b1, 1'b0, 1'b1, 3, 6, 21, 1, 1, 1'b0);
        run_line(1'b0, 1'b0, 1'b0, 1, 5, 20, 1, 1, 1'b0);
        repeat (3) @(negedge clk);
        chk("R8", "seq_err still set", int'(seq_err), 1);
        chk("R7", "queue drained", exp_q.size(), 0);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule